// File: doc/BRIEF.md
# Remote Line to Serial Bridge

This block joins a five-wire binary remote control bus to an asynchronous serial port. The five shared lines carry a crosspoint number from 0 to 31. While the block is only listening, it samples the lines, waits until a new value has stayed steady for a settling period, and then sends a short text update over its UART transmitter.

When a well-formed set command arrives on the UART receiver, the block drives the five lines with the requested number for a fixed window of about 20 ms. It then releases them, and the lines go back to being inputs. While the block drives the lines it does not report its own value as a change. Its stored reference takes the driven number, so releasing the lines causes an update only if the bus then settles to a different value.

The tri-state pad is outside the block. The block presents the drive value and an output enable, and it reads the pad back. At the default settings the clock is 1.2288 MHz, a bit lasts 128 clocks (9600 baud), the settling period is 1229 clocks (1 ms) and the drive window is 24576 clocks (20 ms).

Top module: `rlb_bridge`

## Requirements
- R1: The serial output idles high. Each character is sent as one low start bit, eight data bits least significant first, and one high stop bit, each bit lasting CLKS_PER_BIT clocks.
- R2: When the line value has been steady for STABLE_CLKS clocks and differs from the last reported or driven value, the block sends four characters: 0x55 ('U'), the tens digit and the ones digit in ASCII (0x30 plus the digit), then 0x0D.
- R3: A line value that holds for fewer than STABLE_CLKS clocks before the lines return to the reported value causes no message.
- R4: A command made of 0x53 ('S'), two ASCII decimal digits giving 00 to 31, and 0x0D makes line_oe go high with line_out equal to that number within a few clocks of the final stop bit.
- R5: After a command, line_oe stays high for exactly DRIVE_CLKS clocks and then goes low.
- R6: No update message starts while the lines are driven. After release, a message is sent only if the bus settles to a value different from the driven one, and that message carries the bus value.
- R7: A command whose number is 32 to 99, or a sequence whose bytes are out of order or contain a non-digit, leaves line_oe low.
- R8: A 0x53 byte received in the middle of a command starts a new command.
- R9: A character whose stop bit is low is discarded, and the command parse state is left as it was. The receiver waits for the line to return high before it looks for the next start bit.
- R10: After reset the serial output is high, line_oe is low, line_out is zero, and the reference value is zero.
- R11: A valid command received while the lines are driven replaces the driven value and restarts the full DRIVE_CLKS window.
- R12: Changes detected while a message is being sent are held in a single slot that keeps only the latest value. That value is sent once the current message ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous reset, active high |
| uart_rx | input | 1 | Serial command input, idle high |
| uart_tx | output | 1 | Serial update output, idle high |
| line_in | input | 5 | Bus value read back from the pads |
| line_out | output | 5 | Value to drive onto the bus |
| line_oe | output | 1 | Drive enable for all five pads |

## Verification
The assertions assume that received characters are spaced at least one character time apart, so a parsed command follows a received byte and never repeats on the next clock. They also assume the serial input holds each bit for the full bit period. The bench drives every character with exact bit timing and no gaps shorter than a stop bit. It feeds line_in from line_out whenever line_oe is high, so the pads read back what the block drives, as a real bus would. Line changes that should be ignored are held shorter than the settling period, and line changes that should be reported are held much longer than it.

// File: rtl/rlb_pkg.sv
package rlb_pkg;

    localparam int LINE_W   = 5;
    localparam int MAX_CODE = (1 << LINE_W) - 1;

    typedef logic [LINE_W-1:0] code_t;
    typedef logic [7:0]        byte_t;

    localparam byte_t CH_SET  = 8'h53;
    localparam byte_t CH_UPD  = 8'h55;
    localparam byte_t CH_CR   = 8'h0D;
    localparam byte_t CH_ZERO = 8'h30;
    localparam byte_t CH_NINE = 8'h39;

    // A value on the bus together with a qualifier
    typedef struct packed {
        logic  valid;
        code_t value;
    } code_evt_t;

    typedef enum logic [1:0] {
        PS_WAIT,
        PS_TENS,
        PS_ONES,
        PS_END
    } parse_st_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_st_e;

    function automatic logic is_digit(byte_t b);
        return (b >= CH_ZERO) && (b <= CH_NINE);
    endfunction

    function automatic logic [3:0] digit_of(byte_t b);
        byte_t d;
        d = b - CH_ZERO;
        return d[3:0];
    endfunction

    function automatic logic [6:0] decimal_of(logic [3:0] t, logic [3:0] o);
        return 7'(t) * 7'd10 + 7'(o);
    endfunction

    // Where the parser goes when a byte does not fit the current field
    function automatic parse_st_e resync(byte_t b);
        return (b == CH_SET) ? PS_TENS : PS_WAIT;
    endfunction

    function automatic byte_t tens_char(code_t v);
        return CH_ZERO + byte_t'(32'(v) / 32'd10);
    endfunction

    function automatic byte_t ones_char(code_t v);
        return CH_ZERO + byte_t'(32'(v) % 32'd10);
    endfunction

endpackage

// File: rtl/rlb_uart_rx.sv
module rlb_uart_rx
    import rlb_pkg::*;
#(
    parameter int CLKS_PER_BIT = 128
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rx,
    output logic  byte_valid,
    output byte_t byte_data
);

    localparam int CW = $clog2(CLKS_PER_BIT);
    localparam logic [CW-1:0] BIT_LAST  = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(CLKS_PER_BIT / 2 - 1);

    logic          rx_m, rx_s;
    rx_st_e        st;
    logic [CW-1:0] cnt;
    logic [2:0]    bit_idx;
    byte_t         shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_m       <= 1'b1;
            rx_s       <= 1'b1;
            st         <= RX_IDLE;
            cnt        <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            rx_m       <= rx;
            rx_s       <= rx_m;
            byte_valid <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (!rx_s) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                end
                RX_START: begin
                    if (cnt == HALF_LAST) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        st      <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == BIT_LAST) begin
                        cnt     <= '0;
                        shreg   <= {rx_s, shreg[7:1]};
                        bit_idx <= bit_idx + 1'b1;
                        if (bit_idx == 3'd7) st <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == BIT_LAST) begin
                        cnt <= '0;
                        if (rx_s) begin
                            byte_valid <= 1'b1;
                            byte_data  <= shreg;
                            st         <= RX_IDLE;
                        end else begin
                            st <= RX_BREAK;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_BREAK: begin
                    if (rx_s) st <= RX_IDLE;
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    // R9: a received byte is a one-clock strobe
    p_single_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

endmodule

// File: rtl/rlb_uart_tx.sv
module rlb_uart_tx
    import rlb_pkg::*;
#(
    parameter int CLKS_PER_BIT = 128
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  byte_t data,
    output logic  tx,
    output logic  busy
);

    localparam int CW = $clog2(CLKS_PER_BIT);
    localparam logic [CW-1:0] BIT_LAST = CW'(CLKS_PER_BIT - 1);

    logic [9:0]    sh;
    logic [CW-1:0] cnt;
    logic [3:0]    bit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            sh      <= '1;
            cnt     <= '0;
            bit_idx <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                sh      <= {1'b1, data, 1'b0};
                cnt     <= '0;
                bit_idx <= '0;
            end
        end else if (cnt == BIT_LAST) begin
            cnt <= '0;
            sh  <= {1'b1, sh[9:1]};
            if (bit_idx == 4'd9) busy    <= 1'b0;
            else                 bit_idx <= bit_idx + 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tx = busy ? sh[0] : 1'b1;

    // R1: each frame opens with a low start bit
    p_start_bit_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx);

    // R1: the line holds its level inside a bit period
    p_bit_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |-> $stable(tx));

endmodule

// File: rtl/rlb_cmd_parser.sv
module rlb_cmd_parser
    import rlb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      byte_valid,
    input  byte_t     byte_data,
    output code_evt_t cmd
);

    localparam logic [6:0] MAX7 = 7'(MAX_CODE);

    parse_st_e  st;
    logic [3:0] tens, ones;
    logic [6:0] num;

    assign num = decimal_of(tens, ones);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= PS_WAIT;
            tens <= '0;
            ones <= '0;
            cmd  <= '0;
        end else begin
            cmd.valid <= 1'b0;
            if (byte_valid) begin
                case (st)
                    PS_WAIT: begin
                        if (byte_data == CH_SET) st <= PS_TENS;
                    end
                    PS_TENS: begin
                        if (is_digit(byte_data)) begin
                            tens <= digit_of(byte_data);
                            st   <= PS_ONES;
                        end else begin
                            st <= resync(byte_data);
                        end
                    end
                    PS_ONES: begin
                        if (is_digit(byte_data)) begin
                            ones <= digit_of(byte_data);
                            st   <= PS_END;
                        end else begin
                            st <= resync(byte_data);
                        end
                    end
                    PS_END: begin
                        if (byte_data == CH_CR) begin
                            if (num <= MAX7) begin
                                cmd.valid <= 1'b1;
                                cmd.value <= code_t'(num);
                            end
                            st <= PS_WAIT;
                        end else begin
                            st <= resync(byte_data);
                        end
                    end
                    default: st <= PS_WAIT;
                endcase
            end
        end
    end

    // R4: a command only ever follows a freshly received byte
    p_cmd_after_byte_r4: assert property (@(posedge clk) disable iff (rst)
        cmd.valid |-> $past(byte_valid));

endmodule

// File: rtl/rlb_line_monitor.sv
module rlb_line_monitor
    import rlb_pkg::*;
#(
    parameter int STABLE_CLKS = 1229,
    parameter int DRIVE_CLKS  = 24576
) (
    input  logic      clk,
    input  logic      rst,
    input  code_t     line_in,
    input  code_evt_t cmd,
    output code_t     line_out,
    output logic      line_oe,
    output code_evt_t report
);

    localparam int SW = $clog2(STABLE_CLKS);
    localparam int DW = $clog2(DRIVE_CLKS);
    localparam logic [SW-1:0] SETTLED  = SW'(STABLE_CLKS - 1);
    localparam logic [DW-1:0] WIN_LAST = DW'(DRIVE_CLKS - 1);

    code_t         sync_a, sync_b;
    code_t         cand;
    code_t         ref_val;
    logic [SW-1:0] stab_cnt;
    logic [DW-1:0] win_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a   <= '0;
            sync_b   <= '0;
            cand     <= '0;
            ref_val  <= '0;
            stab_cnt <= '0;
            win_cnt  <= '0;
            line_out <= '0;
            line_oe  <= 1'b0;
            report   <= '0;
        end else begin
            sync_a       <= line_in;
            sync_b       <= sync_a;
            report.valid <= 1'b0;

            // settling counter follows the synchronised bus at all times
            if (sync_b != cand) begin
                cand     <= sync_b;
                stab_cnt <= '0;
            end else if (stab_cnt != SETTLED) begin
                stab_cnt <= stab_cnt + 1'b1;
            end

            if (cmd.valid) begin
                line_oe  <= 1'b1;
                line_out <= cmd.value;
                ref_val  <= cmd.value;
                win_cnt  <= WIN_LAST;
            end else if (line_oe) begin
                if (win_cnt == '0) begin
                    line_oe  <= 1'b0;
                    stab_cnt <= '0;
                end else begin
                    win_cnt <= win_cnt - 1'b1;
                end
            end else if (stab_cnt == SETTLED && sync_b == cand && cand != ref_val) begin
                ref_val      <= cand;
                report.valid <= 1'b1;
                report.value <= cand;
            end
        end
    end

    // R6: nothing is reported while the block owns the lines
    p_no_report_drive_r6: assert property (@(posedge clk) disable iff (rst)
        line_oe |-> !report.valid);

    // R4: the driven value only moves when a new command arrives
    p_out_held_r4: assert property (@(posedge clk) disable iff (rst)
        (line_oe && $past(line_oe) && !$past(cmd.valid)) |-> $stable(line_out));

    // R5: a drive window lasts beyond its first clock
    p_drive_min_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(line_oe) |=> line_oe);

endmodule

// File: rtl/rlb_bridge.sv
module rlb_bridge
    import rlb_pkg::*;
#(
    parameter int CLKS_PER_BIT = 128,
    parameter int STABLE_CLKS  = 1229,
    parameter int DRIVE_CLKS   = 24576
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              uart_rx,
    output logic              uart_tx,
    input  logic [LINE_W-1:0] line_in,
    output logic [LINE_W-1:0] line_out,
    output logic              line_oe
);

    logic      rx_valid;
    byte_t     rx_byte;
    code_evt_t cmd;
    code_evt_t report;

    logic      tx_start;
    logic      tx_busy;
    byte_t     tx_byte;

    code_evt_t pend;
    logic      sending;
    logic [1:0] idx;
    code_t     msg_val;

    rlb_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .rx         (uart_rx),
        .byte_valid (rx_valid),
        .byte_data  (rx_byte)
    );

    rlb_cmd_parser u_parse (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (rx_valid),
        .byte_data  (rx_byte),
        .cmd        (cmd)
    );

    rlb_line_monitor #(
        .STABLE_CLKS (STABLE_CLKS),
        .DRIVE_CLKS  (DRIVE_CLKS)
    ) u_mon (
        .clk      (clk),
        .rst      (rst),
        .line_in  (line_in),
        .cmd      (cmd),
        .line_out (line_out),
        .line_oe  (line_oe),
        .report   (report)
    );

    // Message sequencer: one pending slot, newest value wins
    assign tx_start = sending && !tx_busy;

    always_comb begin
        case (idx)
            2'd0:    tx_byte = CH_UPD;
            2'd1:    tx_byte = tens_char(msg_val);
            2'd2:    tx_byte = ones_char(msg_val);
            default: tx_byte = CH_CR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '0;
            sending <= 1'b0;
            idx     <= '0;
            msg_val <= '0;
        end else begin
            if (report.valid) pend <= report;
            if (!sending && pend.valid && !tx_busy) begin
                sending <= 1'b1;
                idx     <= '0;
                msg_val <= pend.value;
                if (!report.valid) pend.valid <= 1'b0;
            end else if (tx_start) begin
                idx <= idx + 1'b1;
                if (idx == 2'd3) sending <= 1'b0;
            end
        end
    end

    rlb_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .start (tx_start),
        .data  (tx_byte),
        .tx    (uart_tx),
        .busy  (tx_busy)
    );

    // R12: the sequencer never hands a byte to a busy transmitter
    p_no_start_busy_r12: assert property (@(posedge clk) disable iff (rst)
        (sending && $past(tx_start)) |-> tx_busy);

endmodule

// File: tb/rlb_bridge_tb_top.sv
module rlb_bridge_tb_top;
    import rlb_pkg::*;

    localparam int CPB      = 8;
    localparam int STAB     = 16;
    localparam int DRV      = 600;
    localparam int FRAME    = 10 * CPB;
    localparam int MSG_WAIT = 4 * FRAME + STAB + 60;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       tx_line;
    logic [4:0] panel = 5'd0;
    logic [4:0] line_in, line_out;
    logic       line_oe;

    always #10 clk = ~clk;

    // bus model: pads read back the driven value while enabled
    assign line_in = line_oe ? line_out : panel;

    rlb_bridge #(
        .CLKS_PER_BIT (CPB),
        .STABLE_CLKS  (STAB),
        .DRIVE_CLKS   (DRV)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .uart_rx  (rx_line),
        .uart_tx  (tx_line),
        .line_in  (line_in),
        .line_out (line_out),
        .line_oe  (line_oe)
    );

    int checks = 0;
    int errors = 0;

    // serial decoder for the block's output
    byte_t got [0:63];
    int    got_n = 0;
    int    frame_err = 0;
    bit    d_busy = 1'b0;
    int    d_cnt = 0;
    int    d_idx = 0;
    byte_t d_sh = '0;

    always @(negedge clk) begin
        if (!d_busy) begin
            if (tx_line === 1'b0) begin
                d_busy = 1'b1;
                d_cnt  = 0;
            end
        end else begin
            d_cnt++;
            if (d_cnt % CPB == CPB / 2) begin
                d_idx = d_cnt / CPB;
                if (d_idx >= 1 && d_idx <= 8) d_sh[d_idx-1] = tx_line;
                if (d_idx == 9) begin
                    if (tx_line === 1'b1) begin
                        if (got_n < 64) got[got_n] = d_sh;
                        got_n++;
                    end else begin
                        frame_err++;
                    end
                    d_busy = 1'b0;
                end
            end
        end
    end

    // drive-window observer
    int run_len = 0;
    int last_run = 0;
    bit oe_seen = 1'b0;

    always @(negedge clk) begin
        if (line_oe === 1'b1) begin
            run_len++;
            oe_seen = 1'b1;
        end else if (run_len > 0) begin
            last_run = run_len;
            run_len  = 0;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_byte(byte_t b, bit stop_ok = 1'b1);
        rx_line = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            repeat (CPB) @(negedge clk);
        end
        rx_line = stop_ok;
        repeat (CPB) @(negedge clk);
        rx_line = 1'b1;
        if (!stop_ok) repeat (CPB) @(negedge clk);
    endtask

    task automatic send_cmd(int v);
        send_byte(8'h53);
        send_byte(8'(48 + v / 10));
        send_byte(8'(48 + v % 10));
        send_byte(8'h0D);
    endtask

    task automatic expect_msg(int first, int v, string req);
        check(got_n >= first + 4, req, got_n, first + 4);
        check(got[first]   == 8'h55,              req, int'(got[first]),   'h55);
        check(got[first+1] == 8'(48 + v / 10),    req, int'(got[first+1]), 48 + v / 10);
        check(got[first+2] == 8'(48 + v % 10),    req, int'(got[first+2]), 48 + v % 10);
        check(got[first+3] == 8'h0D,              req, int'(got[first+3]), 'h0D);
    endtask

    task automatic wait_release();
        for (int i = 0; i < 2 * DRV + 4 * FRAME && line_oe; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        check(tx_line == 1'b1, "R10", tx_line, 1);
        check(line_oe == 1'b0, "R10", line_oe, 0);
        check(line_out == 5'd0, "R10", line_out, 0);
        repeat (MSG_WAIT) @(negedge clk);
        check(got_n == 0, "R10", got_n, 0);

        // R2, R1: sweep every bus value, each reported once
        for (int k = 1; k <= 32; k++) begin
            int v;
            v = k % 32;
            got_n = 0;
            panel = 5'(v);
            repeat (MSG_WAIT) @(negedge clk);
            check(got_n == 4, "R2", got_n, 4);
            expect_msg(0, v, "R2");
        end
        check(frame_err == 0, "R1", frame_err, 0);

        // R3: short glitch is ignored
        got_n = 0;
        panel = 5'd25;
        repeat (STAB / 3) @(negedge clk);
        panel = 5'd0;
        repeat (MSG_WAIT) @(negedge clk);
        check(got_n == 0, "R3", got_n, 0);

        // R12: changes during a message collapse into the latest one
        got_n = 0;
        panel = 5'd3;
        repeat (STAB + 30) @(negedge clk);
        panel = 5'd9;
        repeat (STAB + 30) @(negedge clk);
        panel = 5'd12;
        repeat (2 * MSG_WAIT) @(negedge clk);
        check(got_n == 8, "R12", got_n, 8);
        expect_msg(0, 3, "R12");
        expect_msg(4, 12, "R12");

        // R4, R5, R6: every command value, panel follows the drive
        for (int v = 0; v < 32; v++) begin
            got_n = 0;
            send_cmd(v);
            repeat (10) @(negedge clk);
            check(line_oe == 1'b1, "R4", line_oe, 1);
            check(line_out == 5'(v), "R4", line_out, v);
            panel = 5'(v);
            wait_release();
            check(last_run == DRV, "R5", last_run, DRV);
            repeat (MSG_WAIT) @(negedge clk);
            check(got_n == 0, "R6", got_n, 0);
        end

        // R11: second command inside the window restarts it
        send_cmd(10);
        send_cmd(11);
        repeat (10) @(negedge clk);
        check(line_out == 5'd11, "R11", line_out, 11);
        panel = 5'd11;
        wait_release();
        check(last_run == 4 * FRAME + DRV, "R11", last_run, 4 * FRAME + DRV);
        repeat (MSG_WAIT) @(negedge clk);

        // R6: release onto a different bus value reports the bus value
        got_n = 0;
        send_cmd(7);
        repeat (10) @(negedge clk);
        check(line_out == 5'd7, "R6", line_out, 7);
        while (line_oe) begin
            @(negedge clk);
        end
        check(got_n == 0, "R6", got_n, 0);
        repeat (MSG_WAIT) @(negedge clk);
        check(got_n == 4, "R6", got_n, 4);
        expect_msg(0, 11, "R6");

        // R7: out-of-range and malformed commands
        oe_seen = 1'b0;
        send_cmd(32);
        send_cmd(45);
        send_cmd(99);
        repeat (20) @(negedge clk);
        check(!oe_seen, "R7", oe_seen, 0);
        send_byte(8'h53); send_byte(8'h31); send_byte(8'h58); send_byte(8'h0D);
        send_byte(8'h53); send_byte(8'h35); send_byte(8'h0D);
        send_byte(8'h41); send_byte(8'h30); send_byte(8'h31); send_byte(8'h0D);
        repeat (20) @(negedge clk);
        check(!oe_seen, "R7", oe_seen, 0);

        // R8: stray set byte restarts the command
        send_byte(8'h53); send_byte(8'h31);
        send_byte(8'h53); send_byte(8'h32); send_byte(8'h33); send_byte(8'h0D);
        repeat (10) @(negedge clk);
        check(line_oe == 1'b1, "R8", line_oe, 1);
        check(line_out == 5'd23, "R8", line_out, 23);
        panel = 5'd23;
        wait_release();

        // R9: byte with low stop bit dropped, parse state kept
        oe_seen = 1'b0;
        send_byte(8'h53); send_byte(8'h30); send_byte(8'h34);
        send_byte(8'h0D, 1'b0);
        repeat (20) @(negedge clk);
        check(!oe_seen, "R9", oe_seen, 0);
        send_byte(8'h0D);
        repeat (10) @(negedge clk);
        check(line_out == 5'd4 && line_oe, "R9", line_out, 4);
        panel = 5'd4;
        wait_release();
        repeat (20) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule